// File: doc/BRIEF.md
# DMA interrupt status controller

This block gathers interrupt events from a DMA-driven Ethernet MAC into one status register and drives a single CPU interrupt line. Seven event sources set sticky status flags: link change, transmit completion, receive completion, transmit buffer unavailable, receive buffer unavailable, transmit stopped and receive stopped. A flag is set by an edge on its input, not by the input's level. Once set, it stays set until software clears it.

The CPU reaches two 32-bit registers over a plain register bus with address, write enable, write data and registered read data. One register holds the status flags. The other holds one enable bit per flag. Software clears flags by writing ones. Reading a register has no side effect. The interrupt line is active while any flag is set and its enable bit is also set.

Receive-buffer-unavailable reporting is gated. Only the first fetch of a descriptor the device does not own raises the flag. Further not-owned fetches stay silent until the device fetches a descriptor it does own.

Top module: `dma_irq_ctrl`

## Requirements
- R1: Register layout. Both registers use the same seven bit positions in the upper part of the word:
  - bit 31: link change
  - bit 30: transmit done
  - bit 29: receive done
  - bit 28: transmit buffer unavailable
  - bit 27: receive buffer unavailable
  - bit 26: transmit stopped
  - bit 25: receive stopped

  Bits 24 to 0 always read 0, and writes to them are ignored. The status register is at word address 0 and the enable register at word address 1. Any other address reads 0.
- R2: The transmit done, receive done, transmit buffer unavailable, transmit stopped and receive stopped flags set on a 0-to-1 transition of their inputs. An input held high does not set its flag again after the flag is cleared.
- R3: Writing 1 to a status bit position clears that flag. Writing 0 leaves the flag unchanged.
- R4: A read of the status register leaves every flag unchanged.
- R5: A write to address 1 loads the seven enable bits. All enable bits are 0 after reset, and they read back at the same positions.
- R6: `irq_o` is 1 exactly when some flag and its enable bit are both 1. It follows in the same cycle that the status or enable change becomes visible.
- R7: The link change flag sets on any transition of `ev_link`, rising or falling. After reset the previous link value is taken as 0.
- R8: When `rx_fetch_vld` is 1 with `rx_fetch_owned` 0 (descriptor not owned by the device), the receive buffer unavailable flag sets only if the gate is armed. Such a fetch disarms the gate. A fetch with `rx_fetch_owned` 1 re-arms it. The gate is armed after reset.
- R9: If a set event and a write-1-to-clear hit the same flag in the same cycle, the flag ends up 1.
- R10: A synchronous reset clears all flags, enables, `irq_o` and `bus_rdata`. Read data appears one clock after the address is presented, and it reflects the register values before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_link | input | 1 | Link state level; either transition is an event |
| ev_tx_done | input | 1 | Transmit completion event |
| ev_rx_done | input | 1 | Receive completion event |
| ev_tx_bufna | input | 1 | Transmit buffer unavailable event |
| ev_tx_stop | input | 1 | Transmit process stopped event |
| ev_rx_stop | input | 1 | Receive process stopped event |
| rx_fetch_vld | input | 1 | Receive descriptor fetch strobe |
| rx_fetch_owned | input | 1 | Fetched receive descriptor is owned by the device |
| bus_addr | input | ADDR_W | Register word address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_o | output | 1 | CPU interrupt request |

## Verification
Two functions can fall in the same cycle: a hardware set event and a software write-1-to-clear aimed at the same flag. A directed case raises the receive-stopped input in the very cycle that a clear of bit 25 is written. It then judges by reading the flag back as 1. Random stimulus also overlaps writes with event edges, fetch strobes and reads, and compares every cycle's read data and interrupt line against a reference model in the bench.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int NEV     = 7;
  localparam int I_LINK  = 6;
  localparam int I_TXD   = 5;
  localparam int I_RXD   = 4;
  localparam int I_TXBU  = 3;
  localparam int I_RXBU  = 2;
  localparam int I_TXSTP = 1;
  localparam int I_RXSTP = 0;
  // Sources whose input is a level that reports a change in either direction
  localparam logic [NEV-1:0] BOTH_EDGE = 7'b1000000;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int W = 7,
  parameter logic [W-1:0] BOTH = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] hit
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (BOTH[i]) begin : g_toggle
      assign hit[i] = lvl[i] ^ prev_q[i];
    end else begin : g_rise
      assign hit[i] = lvl[i] & ~prev_q[i];
    end
  end
endmodule

// File: rtl/rbu_gate.sv
module rbu_gate (
  input  logic clk,
  input  logic rst,
  input  logic fetch_vld,
  input  logic fetch_owned,
  output logic hit
);
  logic armed_q;

  assign hit = fetch_vld & ~fetch_owned & armed_q;

  always_ff @(posedge clk) begin
    if (rst)            armed_q <= 1'b1;
    else if (fetch_vld) armed_q <= fetch_owned;
  end
endmodule

// File: rtl/irq_stat_regs.sv
module irq_stat_regs #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] stat_q,
  output logic [W-1:0] stat_d
);
  for (genvar i = 0; i < W; i++) begin : g_flag
    // set dominates a simultaneous clear
    assign stat_d[i] = set[i] | (stat_q[i] & ~clr[i]);
    always_ff @(posedge clk) begin
      if (rst) stat_q[i] <= 1'b0;
      else     stat_q[i] <= stat_d[i];
    end
  end
endmodule

// File: rtl/irq_regbus.sv
module irq_regbus #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int W         = 7,
  parameter int STAT_ADDR = 0,
  parameter int ENA_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [W-1:0]      stat_q,
  output logic [W-1:0]      clr,
  output logic [W-1:0]      en_q,
  output logic [W-1:0]      en_d,
  output logic [DATA_W-1:0] rdata
);
  localparam int LSB = DATA_W - W;

  logic sel_stat, sel_ena;
  assign sel_stat = (addr == ADDR_W'(STAT_ADDR));
  assign sel_ena  = (addr == ADDR_W'(ENA_ADDR));

  assign clr  = (we && sel_stat) ? wdata[DATA_W-1:LSB] : '0;
  assign en_d = (we && sel_ena)  ? wdata[DATA_W-1:LSB] : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      rdata <= '0;
    end else begin
      en_q <= en_d;
      if (sel_stat)     rdata <= {stat_q, {LSB{1'b0}}};
      else if (sel_ena) rdata <= {en_q, {LSB{1'b0}}};
      else              rdata <= '0;
    end
  end
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int STAT_ADDR = 0,
  parameter int ENA_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_link,
  input  logic              ev_tx_done,
  input  logic              ev_rx_done,
  input  logic              ev_tx_bufna,
  input  logic              ev_tx_stop,
  input  logic              ev_rx_stop,
  input  logic              rx_fetch_vld,
  input  logic              rx_fetch_owned,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  import dma_irq_pkg::*;

  logic [NEV-1:0] ev_lvl, edge_hit, set, clr, stat_q, stat_d, en_q, en_d;
  logic           rbu_hit;

  assign ev_lvl[I_LINK]  = ev_link;
  assign ev_lvl[I_TXD]   = ev_tx_done;
  assign ev_lvl[I_RXD]   = ev_rx_done;
  assign ev_lvl[I_TXBU]  = ev_tx_bufna;
  assign ev_lvl[I_RXBU]  = 1'b0;
  assign ev_lvl[I_TXSTP] = ev_tx_stop;
  assign ev_lvl[I_RXSTP] = ev_rx_stop;

  irq_edge_det #(.W(NEV), .BOTH(BOTH_EDGE)) u_edge (
    .clk(clk), .rst(rst), .lvl(ev_lvl), .hit(edge_hit)
  );

  rbu_gate u_rbu (
    .clk(clk), .rst(rst), .fetch_vld(rx_fetch_vld),
    .fetch_owned(rx_fetch_owned), .hit(rbu_hit)
  );

  always_comb begin
    set         = edge_hit;
    set[I_RXBU] = rbu_hit;
  end

  irq_stat_regs #(.W(NEV)) u_stat (
    .clk(clk), .rst(rst), .set(set), .clr(clr),
    .stat_q(stat_q), .stat_d(stat_d)
  );

  irq_regbus #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .W(NEV),
    .STAT_ADDR(STAT_ADDR), .ENA_ADDR(ENA_ADDR)
  ) u_bus (
    .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .stat_q(stat_q), .clr(clr), .en_q(en_q), .en_d(en_d), .rdata(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(stat_d & en_d);
  end
endmodule

// File: rtl/dma_irq_chk.sv
module dma_irq_chk #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int STAT_ADDR = 0,
  parameter int W         = 7
) (
  input logic              clk,
  input logic              rst,
  input logic [W-1:0]      stat_q,
  input logic [W-1:0]      en_q,
  input logic [W-1:0]      ev_lvl,
  input logic              rx_fetch_vld,
  input logic              rx_fetch_owned,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq_o
);
  localparam int LSB = DATA_W - W;

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[LSB-1:0] == '0);

  a_r6_irq_implies_pending: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ((stat_q & en_q) != '0));

  a_r6_pending_implies_irq: assert property (@(posedge clk) disable iff (rst)
    ((stat_q & en_q) != '0) |-> irq_o);

  a_r8_rbu_needs_unowned_fetch: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_q[2]) |-> $past(rx_fetch_vld && !rx_fetch_owned));

  for (genvar k = 0; k < W; k++) begin : g_bits
    // R3: a flag only falls after a write of 1 to its position
    a_r3_clear_by_w1c: assert property (@(posedge clk) disable iff (rst)
      $fell(stat_q[k]) |-> $past(bus_we && bus_addr == ADDR_W'(STAT_ADDR) && bus_wdata[LSB+k]));
    if (k != 2 && k != 6) begin : g_pulse
      // R2: a pulse-sourced flag rises only when its input was high
      a_r2_set_needs_event: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_q[k]) |-> $past(ev_lvl[k]));
    end
  end
endmodule

bind dma_irq_ctrl dma_irq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_ADDR(STAT_ADDR), .W(7)
) u_chk (
  .clk(clk), .rst(rst), .stat_q(stat_q), .en_q(en_q), .ev_lvl(ev_lvl),
  .rx_fetch_vld(rx_fetch_vld), .rx_fetch_owned(rx_fetch_owned),
  .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .irq_o(irq_o)
);

// File: tb/dma_irq_ctrl_test.sv
`timescale 1ns/1ps
module dma_irq_ctrl_test;
  localparam int AW = 4;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_link = 0, ev_tx_done = 0, ev_rx_done = 0, ev_tx_bufna = 0;
  logic ev_tx_stop = 0, ev_rx_stop = 0, rx_fetch_vld = 0, rx_fetch_owned = 0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dma_irq_ctrl uut (
    .clk(clk), .rst(rst), .ev_link(ev_link), .ev_tx_done(ev_tx_done),
    .ev_rx_done(ev_rx_done), .ev_tx_bufna(ev_tx_bufna), .ev_tx_stop(ev_tx_stop),
    .ev_rx_stop(ev_rx_stop), .rx_fetch_vld(rx_fetch_vld),
    .rx_fetch_owned(rx_fetch_owned), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // Reference model, built from the requirements
  logic [6:0] m_stat, m_en, m_prev;
  logic       m_arm, m_irq;
  logic [31:0] m_rd;

  function automatic logic [31:0] place(input logic [6:0] v);
    return {v, 25'b0};
  endfunction

  always @(posedge clk) begin
    logic [6:0] cur, setv, clrv;
    cur = {ev_link, ev_tx_done, ev_rx_done, ev_tx_bufna, 1'b0, ev_tx_stop, ev_rx_stop};
    if (rst) begin
      m_stat = '0; m_en = '0; m_prev = '0; m_arm = 1'b1; m_rd = '0; m_irq = 1'b0;
    end else begin
      m_rd = (bus_addr == 0) ? place(m_stat) : (bus_addr == 1) ? place(m_en) : 32'h0;
      setv = cur & ~m_prev;
      setv[6] = cur[6] ^ m_prev[6];
      setv[2] = rx_fetch_vld & ~rx_fetch_owned & m_arm;
      if (rx_fetch_vld) m_arm = rx_fetch_owned;
      m_prev = cur;
      clrv = (bus_we && bus_addr == 0) ? bus_wdata[31:25] : 7'b0;
      m_stat = (m_stat & ~clrv) | setv;
      if (bus_we && bus_addr == 1) m_en = bus_wdata[31:25];
      m_irq = |(m_stat & m_en);
    end
  end

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a; bus_we = 0; step(); d = bus_rdata;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    bus_addr = a; bus_we = 1; bus_wdata = d; step(); bus_we = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #3_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED_0042));
    repeat (3) step();
    rst = 0;
    // R10 reset state
    check32("R10 irq after reset", {31'b0, irq_o}, 32'h0);
    check32("R10 rdata after reset", bus_rdata, 32'h0);
    rd(0, d); check32("R10 status reset", d, 32'h0);
    rd(1, d); check32("R5 enable reset", d, 32'h0);
    // R2 rising edge sets
    ev_tx_done = 1; step(); ev_tx_done = 0; step();
    rd(0, d); check32("R2 tx done set", d, 32'h4000_0000);
    check32("R6 masked irq", {31'b0, irq_o}, 32'h0);
    // R2 held level does not set again
    ev_rx_done = 1; step(); step();
    wr(0, 32'h2000_0000); step();
    rd(0, d); check32("R2 held level", d, 32'h4000_0000);
    ev_rx_done = 0;
    // R4 reads have no side effect
    rd(0, d); rd(0, d); check32("R4 read no clear", d, 32'h4000_0000);
    // R3 w0 no effect, w1 clears
    wr(0, 32'h0); rd(0, d); check32("R3 write zero", d, 32'h4000_0000);
    wr(0, 32'h4000_0000); rd(0, d); check32("R3 w1c", d, 32'h0);
    // R5 / R1 enable register and reserved bits
    wr(1, 32'hFFFF_FFFF); rd(1, d); check32("R1 R5 enable readback", d, 32'hFE00_0000);
    check32("R6 no pending", {31'b0, irq_o}, 32'h0);
    // R6 interrupt
    ev_tx_stop = 1; step(); ev_tx_stop = 0;
    check32("R6 irq with set", {31'b0, irq_o}, 32'h1);
    wr(1, 32'h0);
    check32("R6 irq masked off", {31'b0, irq_o}, 32'h0);
    wr(0, 32'hFE00_0000);
    // R7 link both directions
    ev_link = 1; step(); rd(0, d); check32("R7 link up", d, 32'h8000_0000);
    wr(0, 32'h8000_0000);
    ev_link = 0; step(); rd(0, d); check32("R7 link down", d, 32'h8000_0000);
    wr(0, 32'h8000_0000);
    // R8 receive buffer unavailable gate
    rx_fetch_vld = 1; rx_fetch_owned = 0; step(); rx_fetch_vld = 0;
    rd(0, d); check32("R8 first unowned", d, 32'h0800_0000);
    wr(0, 32'h0800_0000);
    rx_fetch_vld = 1; step(); rx_fetch_vld = 0;
    rd(0, d); check32("R8 repeat unowned", d, 32'h0);
    rx_fetch_vld = 1; rx_fetch_owned = 1; step();
    rx_fetch_owned = 0; step(); rx_fetch_vld = 0;
    rd(0, d); check32("R8 rearmed", d, 32'h0800_0000);
    wr(0, 32'h0800_0000);
    // R9 set wins over clear
    ev_rx_stop = 1; step(); ev_rx_stop = 0; step();
    ev_rx_stop = 1; wr(0, 32'h0200_0000); ev_rx_stop = 0;
    rd(0, d); check32("R9 set beats clear", d, 32'h0200_0000);
    // R1 unused address
    rd(5, d); check32("R1 unused address", d, 32'h0);
    wr(0, 32'hFE00_0000);
    // Random phase against the model (R1-R10 mixed)
    for (int i = 0; i < 3000; i++) begin
      ev_tx_done  = ($urandom % 4) == 0;
      ev_rx_done  = ($urandom % 4) == 0;
      ev_tx_bufna = ($urandom % 4) == 0;
      ev_tx_stop  = ($urandom % 4) == 0;
      ev_rx_stop  = ($urandom % 4) == 0;
      if (($urandom % 8) == 0) ev_link = ~ev_link;
      rx_fetch_vld   = ($urandom % 3) == 0;
      rx_fetch_owned = ($urandom % 2) == 0;
      bus_addr  = AW'($urandom % 4);
      bus_we    = ($urandom % 5) == 0;
      bus_wdata = $urandom;
      step();
      check32("R6 random irq", {31'b0, irq_o}, {31'b0, m_irq});
      check32("R10 random rdata", bus_rdata, m_rd);
    end
    finish_run();
  end
endmodule